// File: doc/BRIEF.md
# Image Scale Factor Calculator

This block works out, for one 2D blit, how the source rectangle must be resized on each axis before the engine rotates it. It takes the source and destination crop sizes, a rotation code and a flag for early hardware revisions. For each axis it returns a mode (none, shrink or enlarge) and a 16-bit fixed-point factor. The factor is the inverse of the resize ratio, normalised to 65536.

A one-cycle start pulse captures the inputs. A single restoring divider then produces one quotient bit per cycle: the horizontal axis first, then the vertical. A one-cycle done pulse marks the moment the new results appear at the outputs. No division operator is used in the hardware.

Because resizing happens before rotation, a quarter-turn exchanges the destination width and height as resize targets. On early revisions, two small corrections are applied to the source size under a quarter-turn. The block also reports the corrected source size in size-minus-one form.

Top module: `scl_factor_calc`

## Requirements
- R1: After reset, busy and done are 0, both modes read none (2'b00), and both factors and both active sizes are 0.
- R2: When the source size on an axis equals its target size, that axis reports mode none (2'b00) and factor 0.
- R3: When the source is larger than the target, the axis reports shrink mode (2'b01). Its factor is floor(target*65536/source)+1, kept to 16 bits.
- R4: When the source is smaller than the target, the axis reports enlarge mode (2'b10). Its factor is floor((source-1)*65536/(target-1)). All sizes must be nonzero.
- R5: Rotation code rot is 0=0°, 1=90°, 2=180°, 3=270°. For codes 1 and 3, the horizontal target is dst_h and the vertical target is dst_w. Otherwise the targets are dst_w and dst_h.
- R6: When early_rev=1 and rot is 1 or 3, two corrections apply. If dst_w equals src_h, the source height drops by 8. If the signed difference src_w-dst_h lies strictly between -16 and 16, the source width drops by 16, wrapping modulo 2^13. In all other cases no correction applies.
- R7: act_w and act_h equal the corrected source width and height minus one.
- R8: done is a single-cycle pulse. It appears on the 35th rising edge after the edge that samples start. busy stays high from the sampling edge until done rises.
- R9: A start pulse that arrives while busy is high is ignored. The running job finishes with its own inputs, and no extra done follows.
- R10: All outputs keep their values between done pulses, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, sampled when idle |
| src_w | input | 13 | Source crop width |
| src_h | input | 13 | Source crop height |
| dst_w | input | 13 | Destination crop width |
| dst_h | input | 13 | Destination crop height |
| rot | input | 2 | Rotation code |
| early_rev | input | 1 | Enables early-revision size corrections |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when results update |
| h_mode | output | 2 | Horizontal mode |
| h_factor | output | 16 | Horizontal factor |
| v_mode | output | 2 | Vertical mode |
| v_factor | output | 16 | Vertical factor |
| act_w | output | 13 | Corrected source width minus one |
| act_h | output | 13 | Corrected source height minus one |

## Verification
The stimulus covers the following cases:
- Equal sizes, pure shrink and pure enlarge, which separate the three per-axis formulas.
- Mixed axes, which show that the two results are not swapped or shared.
- All four rotation codes, which show that only quarter-turns exchange targets.
- The early-revision flag under quarter-turn and under no rotation, including a width correction that wraps below zero. These show the corrections are gated correctly.
- Extreme sizes (8191 against 1) and nearly equal sizes, which stress the divider's bit count and the +1 truncation.
- A start pulse issued mid-run, and input changes after completion, which expose any re-triggering or output leakage.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int SCL_DIM_W  = 13;
  localparam int SCL_FRAC_W = 16;

  typedef enum logic [1:0] {
    SCL_NONE = 2'b00,
    SCL_DOWN = 2'b01,
    SCL_UP   = 2'b10
  } scl_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD_H,
    ST_RUN_H,
    ST_RUN_V
  } scl_state_e;
endpackage

// File: rtl/scl_geom.sv
module scl_geom #(
  parameter int DIM_W = 13
) (
  input  logic [DIM_W-1:0] src_w,
  input  logic [DIM_W-1:0] src_h,
  input  logic [DIM_W-1:0] dst_w,
  input  logic [DIM_W-1:0] dst_h,
  input  logic [1:0]       rot,
  input  logic             early_rev,
  output logic [DIM_W-1:0] cor_w,
  output logic [DIM_W-1:0] cor_h,
  output logic [DIM_W-1:0] tgt_w,
  output logic [DIM_W-1:0] tgt_h
);
  // true when a and b differ by less than 16 in either direction
  function automatic logic is_near(input logic [DIM_W-1:0] a, input logic [DIM_W-1:0] b);
    logic signed [DIM_W+1:0] d;
    d = $signed({2'b00, a}) - $signed({2'b00, b});
    return (d < 16) && (d > -16);
  endfunction

  logic quarter_turn, fix_en;
  assign quarter_turn = rot[0];
  assign fix_en       = early_rev && quarter_turn;

  assign cor_h = (fix_en && dst_w == src_h) ? src_h - DIM_W'(8)  : src_h;
  assign cor_w = (fix_en && is_near(src_w, dst_h)) ? src_w - DIM_W'(16) : src_w;
  assign tgt_w = quarter_turn ? dst_h : dst_w;
  assign tgt_h = quarter_turn ? dst_w : dst_h;
endmodule

// File: rtl/scl_axis_prep.sv
module scl_axis_prep
  import scl_pkg::*;
#(
  parameter int DIM_W = 13
) (
  input  logic [DIM_W-1:0] src,
  input  logic [DIM_W-1:0] tgt,
  output scl_mode_e        mode,
  output logic [DIM_W-1:0] num_hi,
  output logic [DIM_W-1:0] den,
  output logic             bump
);
  always_comb begin
    if (src == tgt) begin
      mode = SCL_NONE; num_hi = '0; den = DIM_W'(1); bump = 1'b0;
    end else if (src > tgt) begin
      mode = SCL_DOWN; num_hi = tgt; den = src; bump = 1'b1;
    end else begin
      mode = SCL_UP; num_hi = src - DIM_W'(1); den = tgt - DIM_W'(1); bump = 1'b0;
    end
  end
endmodule

// File: rtl/scl_divider.sv
module scl_divider #(
  parameter int DIM_W = 13,
  parameter int STEPS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIM_W-1:0] num_hi,
  input  logic [DIM_W-1:0] den,
  output logic [STEPS-1:0] quo,
  output logic             fin,
  output logic             active
);
  localparam int CNT_W = $clog2(STEPS + 1);

  logic [DIM_W-1:0] rem_q, den_q;
  logic [STEPS-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;

  // one restoring step: shift in a zero, subtract when it fits
  function automatic logic [DIM_W:0] step(input logic [DIM_W-1:0] r, input logic [DIM_W-1:0] d);
    logic [DIM_W:0] sh;
    sh = {r, 1'b0};
    if (sh >= {1'b0, d}) return {1'b1, DIM_W'(sh - {1'b0, d})};
    return {1'b0, sh[DIM_W-1:0]};
  endfunction

  logic [DIM_W:0] nxt;
  assign nxt = step(rem_q, den_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0; den_q <= '0; quo_q <= '0; cnt_q <= '0;
      active <= 1'b0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        rem_q <= num_hi; den_q <= den; quo_q <= '0;
        cnt_q <= CNT_W'(STEPS); active <= 1'b1;
      end else if (active) begin
        rem_q <= nxt[DIM_W-1:0];
        quo_q <= {quo_q[STEPS-2:0], nxt[DIM_W]};
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end

  assign quo = quo_q;

  // R4: partial remainder must stay below the divisor during a run
  p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> rem_q < den_q);
  // R8: completion strobe lasts one cycle
  p_fin_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
endmodule

// File: rtl/scl_factor_calc.sv
module scl_factor_calc
  import scl_pkg::*;
#(
  parameter int DIM_W  = SCL_DIM_W,
  parameter int FRAC_W = SCL_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIM_W-1:0]  src_w,
  input  logic [DIM_W-1:0]  src_h,
  input  logic [DIM_W-1:0]  dst_w,
  input  logic [DIM_W-1:0]  dst_h,
  input  logic [1:0]        rot,
  input  logic              early_rev,
  output logic              busy,
  output logic              done,
  output logic [1:0]        h_mode,
  output logic [FRAC_W-1:0] h_factor,
  output logic [1:0]        v_mode,
  output logic [FRAC_W-1:0] v_factor,
  output logic [DIM_W-1:0]  act_w,
  output logic [DIM_W-1:0]  act_h
);
  localparam int AXES = 2; // 0 = horizontal, 1 = vertical

  scl_state_e state_q;
  logic [DIM_W-1:0] geo_w, geo_h, geo_tw, geo_th;
  logic [DIM_W-1:0] lat_w, lat_h, lat_tw, lat_th;
  logic [DIM_W-1:0] ax_s [AXES];
  logic [DIM_W-1:0] ax_t [AXES];
  logic [DIM_W-1:0] ax_num [AXES];
  logic [DIM_W-1:0] ax_den [AXES];
  scl_mode_e        ax_mode [AXES];
  logic             ax_bump [AXES];
  logic             div_load, div_fin, div_active, sel_v, accept;
  logic [FRAC_W-1:0] div_quo, h_fac_q;

  function automatic logic [FRAC_W-1:0] final_factor(input scl_mode_e m,
                                                     input logic [FRAC_W-1:0] q,
                                                     input logic b);
    if (m == SCL_NONE) return '0;
    return q + FRAC_W'(b);
  endfunction

  scl_geom #(.DIM_W(DIM_W)) u_geom (
    .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
    .rot(rot), .early_rev(early_rev),
    .cor_w(geo_w), .cor_h(geo_h), .tgt_w(geo_tw), .tgt_h(geo_th)
  );

  assign ax_s[0] = lat_w;
  assign ax_t[0] = lat_tw;
  assign ax_s[1] = lat_h;
  assign ax_t[1] = lat_th;

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    scl_axis_prep #(.DIM_W(DIM_W)) u_prep (
      .src(ax_s[a]), .tgt(ax_t[a]), .mode(ax_mode[a]),
      .num_hi(ax_num[a]), .den(ax_den[a]), .bump(ax_bump[a])
    );
  end

  assign accept   = start && (state_q == ST_IDLE);
  assign sel_v    = (state_q == ST_RUN_H);
  assign div_load = (state_q == ST_LOAD_H) || (state_q == ST_RUN_H && div_fin);

  scl_divider #(.DIM_W(DIM_W), .STEPS(FRAC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(div_load),
    .num_hi(sel_v ? ax_num[1] : ax_num[0]),
    .den(sel_v ? ax_den[1] : ax_den[0]),
    .quo(div_quo), .fin(div_fin), .active(div_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lat_w <= '0; lat_h <= '0; lat_tw <= '0; lat_th <= '0;
      h_fac_q <= '0; done <= 1'b0;
      h_mode <= SCL_NONE; v_mode <= SCL_NONE;
      h_factor <= '0; v_factor <= '0; act_w <= '0; act_h <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          lat_w <= geo_w; lat_h <= geo_h; lat_tw <= geo_tw; lat_th <= geo_th;
          state_q <= ST_LOAD_H;
        end
        ST_LOAD_H: state_q <= ST_RUN_H;
        ST_RUN_H: if (div_fin) begin
          h_fac_q <= final_factor(ax_mode[0], div_quo, ax_bump[0]);
          state_q <= ST_RUN_V;
        end
        ST_RUN_V: if (div_fin) begin
          h_mode   <= ax_mode[0];
          v_mode   <= ax_mode[1];
          h_factor <= h_fac_q;
          v_factor <= final_factor(ax_mode[1], div_quo, ax_bump[1]);
          act_w    <= lat_w - DIM_W'(1);
          act_h    <= lat_h - DIM_W'(1);
          done     <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);

  // R8: done is a single pulse and coincides with the end of busy
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_div_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !div_active);
  // R9: captured job geometry never moves while a run is in flight
  p_ign_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(lat_w) && $stable(lat_h) && $stable(lat_tw) && $stable(lat_th));
  // R10: outputs change only together with done
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(h_factor) && $stable(v_factor) && $stable(h_mode)
              && $stable(v_mode) && $stable(act_w) && $stable(act_h));
  // R2: an axis without resizing shows a zero factor
  p_none_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_mode == SCL_NONE |-> h_factor == '0) and (v_mode == SCL_NONE |-> v_factor == '0));
  // R3: only the three defined mode codes appear
  p_mode_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    h_mode != 2'b11 && v_mode != 2'b11);
endmodule

// File: tb/tb_scl_factor_calc.sv
module tb_scl_factor_calc;
  localparam int LAT = 35;
  localparam int NV  = 14;
  // src_w, src_h, dst_w, dst_h, rot, early_rev
  localparam int VEC [NV][6] = '{
    '{  64,  64,   64,   64, 0, 0},
    '{ 200, 100,  100,   50, 0, 0},
    '{ 100,  50,  200,   75, 0, 0},
    '{ 640, 480,  320,  640, 0, 0},
    '{ 640, 480,  480,  640, 1, 0},
    '{ 640, 480,  320,  240, 2, 0},
    '{ 300, 200,  150,  320, 3, 0},
    '{ 640, 480,  480,  640, 1, 1},
    '{ 100, 120,  120,   90, 3, 1},
    '{ 100, 120,  120,   90, 0, 1},
    '{8191,   1,    1, 8191, 0, 0},
    '{5000,  37, 4999,   38, 0, 0},
    '{  20,  20,   50,   30, 1, 1},
    '{  10,  40,    7,    5, 1, 1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, early_rev = 1'b0;
  logic [12:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
  logic [1:0]  rot = '0;
  logic busy, done;
  logic [1:0] h_mode, v_mode;
  logic [15:0] h_factor, v_factor;
  logic [12:0] act_w, act_h;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  scl_factor_calc dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_w(src_w), .src_h(src_h),
    .dst_w(dst_w), .dst_h(dst_h), .rot(rot), .early_rev(early_rev),
    .busy(busy), .done(done), .h_mode(h_mode), .h_factor(h_factor),
    .v_mode(v_mode), .v_factor(v_factor), .act_w(act_w), .act_h(act_h)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-axis reference using plain integer division
  task automatic ref_axis(input int s, input int t, output int m, output int f, output string tag);
    if (s == t) begin m = 0; f = 0; tag = "R2"; end
    else if (s > t) begin m = 1; f = ((t * 65536) / s + 1) % 65536; tag = "R3"; end
    else begin m = 2; f = ((s - 1) * 65536) / (t - 1); tag = "R4"; end
  endtask

  int e_hm, e_hf, e_vm, e_vf, e_aw, e_ah;
  string e_htag, e_vtag, e_gtag;

  task automatic ref_job(input int sw, input int sh, input int dw, input int dh,
                         input int r, input int er);
    int cw, ch, tw, th, d;
    cw = sw; ch = sh;
    e_gtag = (r % 2 == 1) ? ((er != 0) ? "R6" : "R5") : "R7";
    if (er != 0 && r % 2 == 1) begin
      if (dw == sh) ch = (sh - 8) & 8191;
      d = sw - dh;
      if (d < 16 && d > -16) cw = (sw - 16) & 8191;
    end
    tw = (r % 2 == 1) ? dh : dw;
    th = (r % 2 == 1) ? dw : dh;
    ref_axis(cw, tw, e_hm, e_hf, e_htag);
    ref_axis(ch, th, e_vm, e_vf, e_vtag);
    e_aw = (cw - 1) & 8191;
    e_ah = (ch - 1) & 8191;
  endtask

  task automatic drive(input int sw, input int sh, input int dw, input int dh,
                       input int r, input int er);
    src_w = 13'(sw); src_h = 13'(sh); dst_w = 13'(dw); dst_h = 13'(dh);
    rot = 2'(r); early_rev = 1'(er);
  endtask

  task automatic compare_outputs();
    check(e_htag, "h_mode", int'(h_mode), e_hm);
    check(e_htag, "h_factor", int'(h_factor), e_hf);
    check(e_vtag, "v_mode", int'(v_mode), e_vm);
    check(e_vtag, "v_factor", int'(v_factor), e_vf);
    check(e_gtag, "act_w", int'(act_w), e_aw);
    check(e_gtag, "act_h", int'(act_h), e_ah);
  endtask

  // start a job, wait for done, check latency, busy, results and pulse width
  task automatic run_job(input int sw, input int sh, input int dw, input int dh,
                         input int r, input int er);
    int cyc;
    ref_job(sw, sh, dw, dh, r, er);
    @(negedge clk);
    drive(sw, sh, dw, dh, r, er);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (cyc == 5) check("R8", "busy mid-run", int'(busy), 1);
    end
    check("R8", "latency", cyc, LAT);
    compare_outputs();
    @(negedge clk);
    check("R8", "done width", int'(done), 0);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "h_mode", int'(h_mode), 0);
    check("R1", "v_mode", int'(v_mode), 0);
    check("R1", "h_factor", int'(h_factor), 0);
    check("R1", "v_factor", int'(v_factor), 0);
    check("R1", "act_w", int'(act_w), 0);
    check("R1", "act_h", int'(act_h), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_job(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5]);

    // R3: hand value, halving gives 0x8000 + 1
    run_job(200, 200, 100, 100, 0, 0);
    check("R3", "hand h_factor", int'(h_factor), 32769);
    check("R3", "hand v_factor", int'(v_factor), 32769);

    // R9: a second start in the middle of a run is dropped
    begin
      int cyc;
      int extra;
      ref_job(640, 480, 320, 240, 0, 0);
      @(negedge clk);
      drive(640, 480, 320, 240, 0, 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 200) begin
        @(negedge clk);
        cyc++;
        if (cyc == 10) begin
          drive(100, 50, 200, 75, 1, 1);
          start = 1'b1;
        end
        if (cyc == 11) start = 1'b0;
      end
      check("R9", "latency with extra start", cyc, LAT);
      e_htag = "R9"; e_vtag = "R9"; e_gtag = "R9";
      compare_outputs();
      extra = 0;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check("R9", "extra done pulses", extra, 0);

      // R10: outputs hold while inputs change without a start
      drive(33, 77, 1000, 2, 3, 1);
      repeat (20) @(negedge clk);
      e_htag = "R10"; e_vtag = "R10"; e_gtag = "R10";
      compare_outputs();
      check("R10", "busy stays low", int'(busy), 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule